// File: doc/BRIEF.md
# Reverse-Channel Byte Sender with Ping-Pong Buffer Interlock

This block runs on the peripheral side of a parallel-port link and streams the contents of a read buffer to the host over the reverse (peripheral-to-host) direction. The host asks for the reverse direction with an active-low request. The block answers by driving an active-low grant. It then sends one byte at a time with a four-phase handshake: it drives the byte, lowers its strobe, waits for the host acknowledge to rise, raises its strobe, and waits for the host acknowledge to fall before it fetches the next byte.

The buffer is read in fixed host transfer blocks of 2^BLK_LOG2 bytes. At the end of each block the block gives the reverse direction back and waits for the host to issue a fresh request. After 2^BUF_LOG2 bytes in total, the whole buffer has been sent. The block then raises a read-done flag to the coordinator that swaps the ping-pong buffers. It holds that flag until the coordinator returns an OK pulse, and it then starts over from address 0 on the other buffer.

All host control inputs pass through a synchronizer before the control logic uses them. The byte-type line is tied to the data indication, so the block never sends a command byte.

Top module: `ertx_top`

## Requirements
- R1: After reset, the grant `per_rev_ack_n` is 1 and the strobe `per_ack_n` is 1. The bus enable `data_oe` is 0, `rd_finish` is 0 and `buf_rd_addr` is 0.
- R2: The grant goes low and `data_oe` goes high in the same cycle, once the synchronized `host_rev_req_n` is seen low. The strobe is only ever low while both the grant and the bus enable are active.
- R3: `per_data_flag` is 1 in every cycle, so every byte is marked as data.
- R4: The byte at `buf_rd_addr` is placed on `data_o` one cycle before the strobe falls. `data_o` then holds that value while the strobe is low.
- R5: The strobe rises only after the synchronized `host_ack` is seen high. The address advances by one only after the synchronized `host_ack` is seen low again, and it is stable while the strobe is low.
- R6: After each 2^BLK_LOG2 bytes that do not end the buffer, the grant is released and `data_oe` drops. No byte is sent until `host_rev_req_n` has been seen high and then low again.
- R7: After 2^BUF_LOG2 bytes, `rd_finish` rises and the address wraps to 0. While `rd_finish` is high, no byte is sent and no grant is given, whatever the host does.
- R8: A one-cycle `swap_ok` pulse clears `rd_finish`. After a fresh host request, sending restarts from address 0 and reads the new buffer contents.
- R9: Each host control input takes two clock edges to reach the control logic. A request driven low is answered by the grant on the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rev_req_n | input | 1 | Host reverse-direction request, active low, asynchronous |
| host_ack | input | 1 | Host byte acknowledge, asynchronous |
| swap_ok | input | 1 | One-cycle pulse from the buffer swap coordinator |
| buf_rd_data | input | DATA_W | Byte read from the buffer at `buf_rd_addr` |
| buf_rd_addr | output | BUF_LOG2 | Buffer read address |
| data_o | output | DATA_W | Byte driven toward the pad |
| data_oe | output | 1 | Pad drive enable; the pad is tri-stated when low |
| per_ack_n | output | 1 | Peripheral byte strobe, active low |
| per_rev_ack_n | output | 1 | Reverse-direction grant, active low |
| per_data_flag | output | 1 | Byte-type indication, constant 1 (data) |
| rd_finish | output | 1 | Whole buffer sent, waiting for swap |

## Verification
The bench builds the block with BLK_LOG2 = 2 and BUF_LOG2 = 4. This makes a transfer block four bytes long and a buffer sixteen bytes long. Two complete buffers are sent, covering every block boundary, both buffer wraps and the swap interlock in a few hundred cycles. The host inserts handshake delays that vary from block to block. It also raises and drops its request while the block waits for the swap, to show that this stimulus is ignored.

// File: rtl/ertx_pkg.sv
package ertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STROBE,
        ST_TAKEN,
        ST_SETTLE,
        ST_RELEASE,
        ST_SWAP
    } tx_state_e;

endpackage

// File: rtl/ertx_sync.sv
module ertx_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/ertx_addr_ctr.sv
module ertx_addr_ctr #(
    parameter int BLK_LOG2 = 15,
    parameter int BUF_LOG2 = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [BUF_LOG2-1:0] addr,
    output logic                blk_last,
    output logic                buf_last
);

    logic [BUF_LOG2-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (step) addr_d = addr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr     = addr_q;
    assign blk_last = &addr_q[BLK_LOG2-1:0];
    assign buf_last = &addr_q;

endmodule

// File: rtl/ertx_top.sv
module ertx_top #(
    parameter int DATA_W      = 8,
    parameter int BLK_LOG2    = 15,
    parameter int BUF_LOG2    = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_rev_req_n,
    input  logic                host_ack,
    input  logic                swap_ok,
    input  logic [DATA_W-1:0]   buf_rd_data,
    output logic [BUF_LOG2-1:0] buf_rd_addr,
    output logic [DATA_W-1:0]   data_o,
    output logic                data_oe,
    output logic                per_ack_n,
    output logic                per_rev_ack_n,
    output logic                per_data_flag,
    output logic                rd_finish
);
    import ertx_pkg::*;

    localparam int N_SYNC = 2;

    typedef struct packed {
        tx_state_e         st;
        logic              rev_ack_n;
        logic              ack_n;
        logic              oe;
        logic              fin;
        logic [DATA_W-1:0] data;
    } regs_t;

    localparam regs_t RST_REGS = '{st: ST_IDLE, rev_ack_n: 1'b1, ack_n: 1'b1,
                                   oe: 1'b0, fin: 1'b0, data: '0};

    logic [N_SYNC-1:0] sync_out;
    logic              ack_s, req_n_s, req_on;
    logic              step, blk_last, buf_last;
    regs_t             cur_q, nx_d;

    // Host inputs are asynchronous; request idles high, acknowledge idles low.
    ertx_sync #(
        .WIDTH  (N_SYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b01)
    ) sync_i (
        .clk (clk),
        .rst_n(rst_n),
        .din ({host_ack, host_rev_req_n}),
        .dout(sync_out)
    );

    assign ack_s   = sync_out[1];
    assign req_n_s = sync_out[0];
    assign req_on  = ~req_n_s;

    ertx_addr_ctr #(
        .BLK_LOG2(BLK_LOG2),
        .BUF_LOG2(BUF_LOG2)
    ) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .addr    (buf_rd_addr),
        .blk_last(blk_last),
        .buf_last(buf_last)
    );

    always_comb begin
        nx_d = cur_q;
        step = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (req_on) begin
                    nx_d.rev_ack_n = 1'b0;
                    nx_d.oe        = 1'b1;
                    nx_d.st        = ST_LOAD;
                end
            end
            ST_LOAD: begin
                nx_d.data = buf_rd_data;
                nx_d.st   = ST_STROBE;
            end
            ST_STROBE: begin
                nx_d.ack_n = 1'b0;
                nx_d.st    = ST_TAKEN;
            end
            ST_TAKEN: begin
                if (ack_s) begin
                    nx_d.ack_n = 1'b1;
                    nx_d.st    = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (!ack_s) begin
                    step = 1'b1;
                    if (buf_last) begin
                        nx_d.rev_ack_n = 1'b1;
                        nx_d.oe        = 1'b0;
                        nx_d.fin       = 1'b1;
                        nx_d.st        = ST_SWAP;
                    end else if (blk_last) begin
                        nx_d.rev_ack_n = 1'b1;
                        nx_d.oe        = 1'b0;
                        nx_d.st        = ST_RELEASE;
                    end else begin
                        nx_d.st = ST_LOAD;
                    end
                end
            end
            ST_RELEASE: begin
                if (!req_on) nx_d.st = ST_IDLE;
            end
            ST_SWAP: begin
                if (swap_ok) begin
                    nx_d.fin = 1'b0;
                    nx_d.st  = ST_RELEASE;
                end
            end
            default: nx_d = RST_REGS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= RST_REGS;
        else        cur_q <= nx_d;
    end

    assign data_o        = cur_q.data;
    assign data_oe       = cur_q.oe;
    assign per_ack_n     = cur_q.ack_n;
    assign per_rev_ack_n = cur_q.rev_ack_n;
    assign per_data_flag = 1'b1;
    assign rd_finish     = cur_q.fin;

endmodule

// File: rtl/ertx_chk.sv
module ertx_chk #(
    parameter int DATA_W   = 8,
    parameter int BUF_LOG2 = 17
) (
    input logic                clk,
    input logic                rst_n,
    input logic                swap_ok,
    input logic [BUF_LOG2-1:0] buf_rd_addr,
    input logic [DATA_W-1:0]   data_o,
    input logic                data_oe,
    input logic                per_ack_n,
    input logic                per_rev_ack_n,
    input logic                per_data_flag,
    input logic                rd_finish
);

    assert_flag_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        per_data_flag);

    assert_strobe_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !per_ack_n |-> (data_oe && !per_rev_ack_n));

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_ack_n && !$past(per_ack_n)) |-> $stable(data_o));

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !per_ack_n |-> $stable(buf_rd_addr));

    assert_finish_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_finish |-> (per_rev_ack_n && per_ack_n && !data_oe));

    assert_finish_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_finish && !swap_ok) |=> rd_finish);

endmodule

bind ertx_top ertx_chk #(
    .DATA_W  (DATA_W),
    .BUF_LOG2(BUF_LOG2)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .swap_ok      (swap_ok),
    .buf_rd_addr  (buf_rd_addr),
    .data_o       (data_o),
    .data_oe      (data_oe),
    .per_ack_n    (per_ack_n),
    .per_rev_ack_n(per_rev_ack_n),
    .per_data_flag(per_data_flag),
    .rd_finish    (rd_finish)
);

// File: tb/ertx_top_tb_top.sv
module ertx_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int BLKL = 2;
    localparam int BUFL = 4;
    localparam int NBLK = 1 << BLKL;
    localparam int NBUF = 1 << BUFL;
    localparam int WDOG = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_rev_req_n = 1'b1;
    logic host_ack = 1'b0;
    logic swap_ok = 1'b0;
    logic [DW-1:0]   mem [NBUF];
    logic [DW-1:0]   buf_rd_data;
    logic [BUFL-1:0] buf_rd_addr;
    logic [DW-1:0]   data_o;
    logic data_oe, per_ack_n, per_rev_ack_n, per_data_flag, rd_finish;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign buf_rd_data = mem[buf_rd_addr];

    ertx_top #(.DATA_W(DW), .BLK_LOG2(BLKL), .BUF_LOG2(BUFL), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_rev_req_n(host_rev_req_n), .host_ack(host_ack),
        .swap_ok(swap_ok), .buf_rd_data(buf_rd_data), .buf_rd_addr(buf_rd_addr),
        .data_o(data_o), .data_oe(data_oe), .per_ack_n(per_ack_n),
        .per_rev_ack_n(per_rev_ack_n), .per_data_flag(per_data_flag), .rd_finish(rd_finish)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: host inputs seen through a two-entry delay queue,
    // the transfer progress kept as a phase number and a byte index.
    int   m_phase;        // 0 idle,1 fetch,2 strobe,3 await hi,4 await lo,5 await release,6 await swap
    int   m_idx;
    logic m_grant_n, m_strobe_n, m_oe, m_done;
    int   m_data;
    logic rq_q[$];
    logic ak_q[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_idx = 0; m_grant_n = 1; m_strobe_n = 1; m_oe = 0; m_done = 0; m_data = 0;
            rq_q = '{1'b1, 1'b1};
            ak_q = '{1'b0, 1'b0};
        end else begin
            logic rq_seen, ak_seen;
            rq_seen = rq_q.pop_front();
            ak_seen = ak_q.pop_front();
            rq_q.push_back(host_rev_req_n);
            ak_q.push_back(host_ack);
            if (m_phase == 0) begin
                if (!rq_seen) begin m_grant_n = 0; m_oe = 1; m_phase = 1; end
            end else if (m_phase == 1) begin
                m_data = int'(mem[m_idx]); m_phase = 2;
            end else if (m_phase == 2) begin
                m_strobe_n = 0; m_phase = 3;
            end else if (m_phase == 3) begin
                if (ak_seen) begin m_strobe_n = 1; m_phase = 4; end
            end else if (m_phase == 4) begin
                if (!ak_seen) begin
                    m_idx = m_idx + 1;
                    if (m_idx == NBUF) begin
                        m_idx = 0; m_grant_n = 1; m_oe = 0; m_done = 1; m_phase = 6;
                    end else if (m_idx % NBLK == 0) begin
                        m_grant_n = 1; m_oe = 0; m_phase = 5;
                    end else m_phase = 1;
                end
            end else if (m_phase == 5) begin
                if (rq_seen) m_phase = 0;
            end else begin
                if (swap_ok) begin m_done = 0; m_phase = 5; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2", "model grant", int'(per_rev_ack_n), int'(m_grant_n));
            check("R2", "model bus enable", int'(data_oe), int'(m_oe));
            check("R5", "model strobe", int'(per_ack_n), int'(m_strobe_n));
            check("R5", "model address", int'(buf_rd_addr), m_idx);
            check("R4", "model data", int'(data_o), m_data);
            check("R7", "model finish", int'(rd_finish), int'(m_done));
            check("R3", "data flag", int'(per_data_flag), 1);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < NBUF; i++) mem[i] = DW'((i * 37 + seed) & 8'hff);
    endtask

    // Host side: sends one transfer block with handshake delay `gap`.
    task automatic host_block(input int first, input int gap);
        host_rev_req_n = 1'b0;
        for (int b = 0; b < NBLK; b++) begin
            while (per_ack_n) tick();
            check("R4", "byte at strobe", int'(data_o), int'(mem[first + b]));
            check("R5", "address at strobe", int'(buf_rd_addr), first + b);
            repeat (gap) tick();
            host_ack = 1'b1;
            while (!per_ack_n) tick();
            repeat (gap) tick();
            host_ack = 1'b0;
        end
        while (!per_rev_ack_n) tick();
        check("R6", "bus released at block end", int'(data_oe), 0);
        host_rev_req_n = 1'b1;
        repeat (3) tick();
    endtask

    initial begin
        fill(5);
        repeat (3) tick();
        check("R1", "reset grant", int'(per_rev_ack_n), 1);
        check("R1", "reset strobe", int'(per_ack_n), 1);
        check("R1", "reset bus enable", int'(data_oe), 0);
        check("R1", "reset finish", int'(rd_finish), 0);
        check("R1", "reset address", int'(buf_rd_addr), 0);
        rst_n = 1'b1;
        repeat (3) tick();

        // R9: request crosses two synchronizer stages before the grant register.
        host_rev_req_n = 1'b0;
        tick(); tick();
        check("R9", "grant not yet after two edges", int'(per_rev_ack_n), 1);
        tick();
        check("R2", "grant after third edge", int'(per_rev_ack_n), 0);
        check("R2", "bus enabled with grant", int'(data_oe), 1);

        for (int k = 0; k < NBUF / NBLK; k++) begin
            host_block(k * NBLK, k % 3);
            if (k < NBUF / NBLK - 1) begin
                repeat (6) tick();
                check("R6", "no grant without new request", int'(per_rev_ack_n), 1);
            end
        end

        check("R7", "finish after full buffer", int'(rd_finish), 1);
        check("R7", "address wrapped", int'(buf_rd_addr), 0);
        host_rev_req_n = 1'b0;
        for (int i = 0; i < 12; i++) begin
            tick();
            host_ack = (i % 4 == 1);
            check("R7", "no strobe while finished", int'(per_ack_n), 1);
        end
        check("R7", "no grant while finished", int'(per_rev_ack_n), 1);
        host_ack = 1'b0;
        host_rev_req_n = 1'b1;
        repeat (4) tick();
        check("R7", "finish held until swap", int'(rd_finish), 1);

        fill(101);
        swap_ok = 1'b1;
        tick();
        swap_ok = 1'b0;
        tick();
        check("R8", "finish cleared by swap", int'(rd_finish), 0);
        repeat (3) tick();

        for (int k = 0; k < NBUF / NBLK; k++) host_block(k * NBLK, (k + 1) % 4);
        check("R8", "second buffer finished", int'(rd_finish), 1);
        swap_ok = 1'b1;
        tick();
        swap_ok = 1'b0;
        repeat (4) tick();

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule